// File: doc/BRIEF.md
# Transmit Source-Address Inserter

This block sits in a transmit path that carries a frame as a 4-bit nibble stream qualified by an enable line, one nibble per clock-enable strobe. Every frame opens with the 12 nibbles of the destination address. When the insertion setting is on, the block emits those 12 nibbles unchanged, then emits the 48-bit station address as 12 nibbles, and then the rest of the input frame. The upstream source cannot be paused, so the nibbles that arrive while the address is going out are held in a 12-stage delay line. The output enable therefore stays high 12 strobes longer than the input enable.

The stream has no ready signal, and neither side can apply back-pressure. The upstream side must present one nibble on every strobe while its enable is high. The downstream side must accept one nibble on every strobe while the output enable is high. A new frame may start once 12 idle strobes have followed the last input nibble of the previous frame. When the setting is off, the frame is assumed to carry its own source address already, and it passes through with one strobe of latency. A cancel input ends the frame at once.

Top module: `txsa_inserter`

## Requirements
- R1: After reset the output enable is low and the output nibble is zero.
- R2: The outputs and all internal state change only on clock edges where the strobe `ce` is high. Cancel and reset are the two exceptions.
- R3: With insertion off, the output at a strobe equals the input enable and the input nibble presented at that same strobe, and it is visible after that edge.
- R4: With insertion on, the first 12 input nibbles of a frame (the destination address) appear at the output at the strobes that carry them.
- R5: With insertion on, output strobes 12 to 23 of the frame carry the station address `{sa_hi, sa_lo}`. The most significant octet (`sa_hi[15:8]`) goes first, and each octet is sent with its low nibble first.
- R6: With insertion on, input nibble k (k >= 12) appears at output strobe k+12. The output enable stays high for exactly 12 strobes more than the input enable.
- R7: With insertion on, a frame shorter than 12 nibbles passes through unchanged, and no address is added.
- R8: The insertion setting and the address are captured at the first strobe of a frame. Changes to them later in the same frame have no effect on that frame.
- R9: When `cancel` is high at a clock edge, the output enable is low after that edge whatever the strobe is doing. Nibbles still waiting in the delay line are discarded and never reach the output.
- R10: A frame that starts 12 idle strobes after the last input nibble of an inserted frame is handled in full. No nibble is lost, and none from the earlier frame is mixed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock-enable strobe; the stream advances one nibble per strobe |
| cfg_ins | input | 1 | Insertion setting, 1 = insert the station address |
| cancel | input | 1 | Abort the frame in progress and flush the delay line |
| sa_hi | input | 16 | Station address, upper 16 bits |
| sa_lo | input | 32 | Station address, lower 32 bits |
| in_en | input | 1 | Input frame enable |
| in_nib | input | 4 | Input nibble |
| out_en | output | 1 | Output frame enable |
| out_nib | output | 4 | Output nibble |

## Verification
Every output nibble is registered, so the result of a strobe is visible one clock after the edge that carries it. The bench samples on the falling edge right after each strobe and compares against output index k of its own arithmetic model. Address nibbles fall due at indices 12 to 23, and payload nibble k falls due at index k+12. On the clocks between strobes the bench checks that nothing moved. A cancel takes effect at the first edge where it is high, so the output enable is checked at the next falling edge and then for 14 further strobes to confirm that the flushed nibbles never come out.

// File: rtl/txsa_pkg.sv
package txsa_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_DEST,
    ST_ADDR,
    ST_BODY
  } txsa_state_e;
endpackage

// File: rtl/txsa_nib_delay.sv
module txsa_nib_delay #(
  parameter int DEPTH = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce,
  input  logic                      flush,
  input  logic                      in_v,
  input  logic [txsa_pkg::NIB_W-1:0] in_nib,
  output logic [txsa_pkg::NIB_W-1:0] tap_nib,
  output logic                      tap_v,
  output logic                      next_v
);
  logic [txsa_pkg::NIB_W-1:0] nib_q [DEPTH];
  logic [DEPTH-1:0]           v_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          nib_q[g] <= '0;
          v_q[g]   <= 1'b0;
        end else if (flush) begin
          v_q[g]   <= 1'b0;
        end else if (ce) begin
          nib_q[g] <= in_nib;
          v_q[g]   <= in_v;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          nib_q[g] <= '0;
          v_q[g]   <= 1'b0;
        end else if (flush) begin
          v_q[g]   <= 1'b0;
        end else if (ce) begin
          nib_q[g] <= nib_q[g-1];
          v_q[g]   <= v_q[g-1];
        end
      end
    end
  end

  assign tap_nib = nib_q[DEPTH-1];
  assign tap_v   = v_q[DEPTH-1];
  assign next_v  = v_q[DEPTH-2];
endmodule

// File: rtl/txsa_addr_mux.sv
module txsa_addr_mux #(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 4
) (
  input  logic [8*ADDR_BYTES-1:0]     addr,
  input  logic [IDX_W-1:0]            sel,
  output logic [txsa_pkg::NIB_W-1:0]  nib
);
  localparam int NIBS = 2 * ADDR_BYTES;

  logic [txsa_pkg::NIB_W-1:0] nib_arr [NIBS];

  // Octets leave most significant first; within an octet the low nibble leads.
  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign nib_arr[g] = addr[8*(ADDR_BYTES-1-g/2) + 4*(g%2) +: 4];
  end

  always_comb begin
    nib = '0;
    for (int i = 0; i < NIBS; i++) begin
      if (sel == IDX_W'(i)) nib = nib_arr[i];
    end
  end
endmodule

// File: rtl/txsa_ctrl.sv
module txsa_ctrl
  import txsa_pkg::*;
#(
  parameter int DEST_NIBS = 12,
  parameter int ADDR_NIBS = 12,
  parameter int SA_W      = 48,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             cancel,
  input  logic             cfg_ins,
  input  logic [SA_W-1:0]  sa,
  input  logic             in_en,
  input  logic [NIB_W-1:0] in_nib,
  input  logic [NIB_W-1:0] addr_nib,
  input  logic [NIB_W-1:0] dly_nib,
  input  logic             dly_v,
  input  logic             dly_v_next,
  output logic [SA_W-1:0]  sa_q,
  output logic [IDX_W-1:0] idx,
  output logic             out_en,
  output logic [NIB_W-1:0] out_nib
);
  localparam logic [IDX_W-1:0] DEST_LAST = IDX_W'(DEST_NIBS - 1);
  localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_NIBS - 1);

  txsa_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      sa_q    <= '0;
      out_en  <= 1'b0;
      out_nib <= '0;
    end else if (cancel) begin
      state   <= ST_IDLE;
      idx     <= '0;
      out_en  <= 1'b0;
    end else if (ce) begin
      case (state)
        ST_IDLE: begin
          out_en  <= in_en;
          out_nib <= in_nib;
          if (in_en) begin
            sa_q <= sa;
            if (cfg_ins) begin
              state <= ST_DEST;
              idx   <= IDX_W'(1);
            end else begin
              state <= ST_PASS;
            end
          end
        end
        ST_PASS: begin
          out_en  <= in_en;
          out_nib <= in_nib;
          if (!in_en) state <= ST_IDLE;
        end
        ST_DEST: begin
          out_en  <= in_en;
          out_nib <= in_nib;
          if (!in_en) begin
            state <= ST_IDLE;
            idx   <= '0;
          end else if (idx == DEST_LAST) begin
            state <= ST_ADDR;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_ADDR: begin
          out_en  <= 1'b1;
          out_nib <= addr_nib;
          if (idx == ADDR_LAST) begin
            idx   <= '0;
            state <= dly_v_next ? ST_BODY : ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_BODY: begin
          out_en  <= dly_v;
          out_nib <= dly_nib;
          if (!dly_v_next) state <= ST_IDLE;
        end
        default: begin
          state  <= ST_IDLE;
          out_en <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/txsa_inserter.sv
module txsa_inserter #(
  parameter int ADDR_BYTES = 6,
  parameter int DEST_BYTES = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ce,
  input  logic                          cfg_ins,
  input  logic                          cancel,
  input  logic [8*ADDR_BYTES-33:0]      sa_hi,
  input  logic [31:0]                   sa_lo,
  input  logic                          in_en,
  input  logic [txsa_pkg::NIB_W-1:0]    in_nib,
  output logic                          out_en,
  output logic [txsa_pkg::NIB_W-1:0]    out_nib
);
  localparam int SA_W      = 8 * ADDR_BYTES;
  localparam int ADDR_NIBS = 2 * ADDR_BYTES;
  localparam int DEST_NIBS = 2 * DEST_BYTES;
  localparam int MAX_NIBS  = (ADDR_NIBS > DEST_NIBS) ? ADDR_NIBS : DEST_NIBS;
  localparam int IDX_W     = $clog2(MAX_NIBS);

  logic [SA_W-1:0]              sa_q;
  logic [IDX_W-1:0]             idx;
  logic [txsa_pkg::NIB_W-1:0]   addr_nib;
  logic [txsa_pkg::NIB_W-1:0]   dly_nib;
  logic                         dly_v;
  logic                         dly_v_next;

  txsa_nib_delay #(.DEPTH(ADDR_NIBS)) dly_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce),
    .flush   (cancel),
    .in_v    (in_en),
    .in_nib  (in_nib),
    .tap_nib (dly_nib),
    .tap_v   (dly_v),
    .next_v  (dly_v_next)
  );

  txsa_addr_mux #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) mux_i (
    .addr (sa_q),
    .sel  (idx),
    .nib  (addr_nib)
  );

  txsa_ctrl #(
    .DEST_NIBS (DEST_NIBS),
    .ADDR_NIBS (ADDR_NIBS),
    .SA_W      (SA_W),
    .IDX_W     (IDX_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (ce),
    .cancel     (cancel),
    .cfg_ins    (cfg_ins),
    .sa         ({sa_hi, sa_lo}),
    .in_en      (in_en),
    .in_nib     (in_nib),
    .addr_nib   (addr_nib),
    .dly_nib    (dly_nib),
    .dly_v      (dly_v),
    .dly_v_next (dly_v_next),
    .sa_q       (sa_q),
    .idx        (idx),
    .out_en     (out_en),
    .out_nib    (out_nib)
  );
endmodule

// File: rtl/txsa_inserter_chk.sv
module txsa_inserter_chk #(
  parameter int ADDR_NIBS = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce,
  input logic       cancel,
  input logic       in_en,
  input logic       out_en,
  input logic [3:0] out_nib
);
  localparam int TAIL_W   = $clog2(ADDR_NIBS + 2) + 1;
  localparam int TAIL_MAX = (1 << TAIL_W) - 1;

  // Strobes with the input idle since the input enable was last high.
  logic [TAIL_W-1:0] tail_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tail_cnt <= '0;
    else if (ce) begin
      if (in_en) tail_cnt <= '0;
      else if (tail_cnt != TAIL_W'(TAIL_MAX)) tail_cnt <= tail_cnt + 1'b1;
    end
  end

  assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !cancel) |=> ($stable(out_en) && $stable(out_nib)));

  assert_cancel_drops_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !out_en);

  assert_frame_starts_from_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> $past(in_en && ce));

  assert_stretch_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (tail_cnt <= TAIL_W'(ADDR_NIBS)));
endmodule

bind txsa_inserter txsa_inserter_chk #(.ADDR_NIBS(2 * ADDR_BYTES)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce      (ce),
  .cancel  (cancel),
  .in_en   (in_en),
  .out_en  (out_en),
  .out_nib (out_nib)
);

// File: tb/txsa_inserter_tb_top.sv
`timescale 1ns/1ps
module txsa_inserter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0;
  logic        cfg_ins = 1'b0;
  logic        cancel = 1'b0;
  logic [15:0] sa_hi = 16'h0;
  logic [31:0] sa_lo = 32'h0;
  logic        in_en = 1'b0;
  logic [3:0]  in_nib = 4'h0;
  logic        out_en;
  logic [3:0]  out_nib;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  txsa_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .cfg_ins(cfg_ins), .cancel(cancel),
    .sa_hi(sa_hi), .sa_lo(sa_lo), .in_en(in_en), .in_nib(in_nib),
    .out_en(out_en), .out_nib(out_nib)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL R2 watchdog: cycles=%0d expected<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic c, input logic e, input logic [3:0] n, input logic can);
    ce = c; in_en = e; in_nib = n; cancel = can;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] dat(input int k, input int seed);
    return 4'((k * 7 + seed * 3 + 5) & 15);
  endfunction

  function automatic logic [3:0] anib(input logic [47:0] sa, input int j);
    logic [7:0] oct;
    oct = 8'((sa >> (8 * (5 - j / 2))) & 48'hFF);
    return (j % 2) ? oct[7:4] : oct[3:0];
  endfunction

  // Expected {enable, nibble} at output strobe k of a frame of n nibbles.
  function automatic logic [4:0] expect_at(input int k, input int n, input bit ins,
                                           input logic [47:0] sa, input int seed);
    if (ins && n >= 12) begin
      if (k < 12)          return {1'b1, dat(k, seed)};
      else if (k < 24)     return {1'b1, anib(sa, k - 12)};
      else if (k < n + 12) return {1'b1, dat(k - 12, seed)};
      else                 return 5'h0;
    end
    if (k < n) return {1'b1, dat(k, seed)};
    return 5'h0;
  endfunction

  task automatic run_frame(input int n, input bit ins, input int per, input int seed);
    logic [47:0] sa;
    logic [4:0]  e;
    string       req;
    sa = {16'(seed * 40503 + 17), 32'(seed * 32'h9E3779B1 + 32'h1234)};
    cfg_ins = ins; sa_hi = sa[47:32]; sa_lo = sa[31:0];
    for (int k = 0; k < n + 12; k++) begin
      for (int i = 0; i < per - 1; i++) begin
        logic       pe;
        logic [3:0] pn;
        pe = out_en; pn = out_nib;
        tick(1'b0, k < n, dat(k, seed), 1'b0);
        check(out_en == pe && out_nib == pn, "R2 hold", {out_en, out_nib}, {pe, pn});
      end
      tick(1'b1, k < n, dat(k, seed), 1'b0);
      if (k == 0) begin
        cfg_ins = ~ins; sa_hi = ~sa[47:32]; sa_lo = ~sa[31:0]; // R8: ignored mid-frame
      end
      e = expect_at(k, n, ins, sa, seed);
      if (!ins)          req = "R3 pass";
      else if (n < 12)   req = "R7 short";
      else if (k < 12)   req = "R4 dest";
      else if (k < 24)   req = "R5 addr";
      else               req = "R6 body";
      if (k == 0 && seed > 0) req = {req, " R8 R10"};
      check(out_en == e[4], req, out_en, e[4]);
      if (e[4]) check(out_nib == e[3:0], req, out_nib, e[3:0]);
    end
  endtask

  task automatic cancel_case(input int at, input bit with_ce);
    logic [47:0] sa;
    sa = 48'hA1B2_C3D4_E5F6;
    cfg_ins = 1'b1; sa_hi = sa[47:32]; sa_lo = sa[31:0];
    for (int k = 0; k < at; k++) tick(1'b1, 1'b1, dat(k, 9), 1'b0);
    check(out_en == 1'b1, "R9 pre", out_en, 1);
    tick(with_ce, 1'b0, 4'h0, 1'b1);
    check(out_en == 1'b0, "R9 drop", out_en, 0);
    for (int k = 0; k < 14; k++) begin
      tick(1'b1, 1'b0, 4'h0, 1'b0);
      check(out_en == 1'b0, "R9 flushed", out_en, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_en == 1'b0 && out_nib == 4'h0, "R1 reset", {out_en, out_nib}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_en == 1'b0, "R1 after release", out_en, 0);
    for (int per = 1; per <= 3; per += 2)
      for (int ins = 0; ins < 2; ins++)
        for (int n = 0; n <= 40; n++)
          run_frame(n, ins[0], per, n + 1 + ins * 50);
    cancel_case(16, 1'b0);
    run_frame(30, 1'b1, 1, 77);
    cancel_case(28, 1'b1);
    run_frame(13, 1'b1, 1, 78);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule